// File: doc/BRIEF.md
# Four-Channel Configurable Tone Divider

This block generates four 1-bit tone signals for a sound generator. Each channel is a down-counting frequency divider with its own 8-bit reload byte. On every underflow a channel either flips its output, which gives a square wave, or copies one bit of a shared pseudo-random sequence, which gives noise. A single global option byte changes how the channels are clocked. It selects the base tick rate. It can give channel 1 or channel 3 the full master clock. It can merge neighbouring channels into 16-bit dividers. It can also gate channel 1 or channel 3 through a simple high-pass stage that is clocked by the next channel up.

A host writes the option byte, the four reload bytes and a per-channel noise-select mask through a small synchronous write port. The base ticks come from a prescaler on the master clock. Two maximal-length shift registers, 9 and 17 bits long, advance on every master clock and supply the noise bit. Volume, mixing and any analog path lie outside this block.

Top module: `quad_tone_divider`

## Requirements
- R1: After reset every channel output is 0, and the option byte, the reload bytes and the noise mask are all zero.
- R2: A write with `wr_en` high stores `wr_data` at the next rising clock edge. Address 0, 1, 2 and 3 hold the reload bytes of channels 1, 2, 3 and 4. Address 4 holds the option byte. Address 5 holds the noise mask, where bit i selects noise for channel i+1.
- R3: When a channel is in square mode with reload N, its output toggles once every N+1 of its enabled ticks. The counter counts down, and when it is zero on an enabled tick it reloads N.
- R4: With option bit 0 clear, the base tick fires once every 28 master clocks. With option bit 0 set, it fires once every 114 master clocks.
- R5: Option bit 6 makes channel 1 count on every master clock. Option bit 5 does the same for channel 3. Otherwise a channel counts on the base tick.
- R6: Option bit 4 joins channels 1 and 2 into one 16-bit divider with reload {ch2,ch1}. The divider counts on channel 1's clock, and channel 2's output toggles every ({ch2,ch1}+1) of those ticks while channel 1's output stays 0. Option bit 3 does the same for channels 3 and 4.
- R7: A channel in noise mode changes its output only on its own underflows. On each underflow it loads the current polynomial bit.
- R8: With option bit 7 set, the noise bit repeats with period 511 master clocks (9-bit polynomial). With bit 7 clear, the period is 131071 master clocks (17-bit polynomial).
- R9: Option bit 2 makes channel 1's output the XOR of its divider output with a flop that samples that divider output on each channel 2 underflow. Option bit 1 does the same for channel 3, clocked by channel 4. If the two channels underflow in the same cycle every time, the filtered output settles at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address (reloads, option byte, noise mask) |
| wr_data | input | 8 | Write data |
| chan_out | output | 4 | Tone outputs, bit i is channel i+1 |

## Verification
Two functions of this block can fall in the same cycle. The high-pass flop takes its sample from the filtered channel's divider output on the very edge where that divider also toggles. The bench provokes this by giving channel 1 and channel 2 (and channel 3 and channel 4) equal reloads on the shared base tick, so the pairs underflow in lockstep from reset. The result is correct only if the flop captures the value from before the toggle, and the bench judges this by requiring the filtered output to hold 1 continuously. The joined-mode wrap, where the low byte and the full 16-bit count reach zero together, is judged by exact periods such as 513 cycles for reload 0x0200.

// File: rtl/snd_div_pkg.sv
package snd_div_pkg;
  // write-port map
  localparam int A_RELOAD_BASE = 0;
  localparam int A_OPTION      = 4;
  localparam int A_NOISE_MASK  = 5;
  // option byte fields
  localparam int OPT_SLOW_TICK = 0;
  localparam int OPT_HP_CH3    = 1;
  localparam int OPT_HP_CH1    = 2;
  localparam int OPT_JOIN34    = 3;
  localparam int OPT_JOIN12    = 4;
  localparam int OPT_FAST_CH3  = 5;
  localparam int OPT_FAST_CH1  = 6;
  localparam int OPT_POLY_SHORT = 7;
endpackage

// File: rtl/snd_div_prescaler.sv
module snd_div_prescaler #(
  parameter int DIV_FAST = 28,
  parameter int DIV_SLOW = 114
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_sel,
  output logic tick
);
  localparam int CW = $clog2(DIV_SLOW);

  logic [CW-1:0] cnt_q, cnt_d, last_val;

  always_comb begin
    last_val = slow_sel ? CW'(DIV_SLOW - 1) : CW'(DIV_FAST - 1);
    tick     = 1'b0;
    cnt_d    = cnt_q + CW'(1);
    // >= keeps a switch to the short ratio from running past the limit
    if (cnt_q >= last_val) begin
      tick  = 1'b1;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/snd_div_poly.sv
module snd_div_poly #(
  parameter int SHORT_LEN = 9,
  parameter int SHORT_TAP = 4,
  parameter int LONG_LEN  = 17,
  parameter int LONG_TAP  = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic short_sel,
  output logic noise_bit
);
  logic [SHORT_LEN-1:0] sh_q, sh_d;
  logic [LONG_LEN-1:0]  lg_q, lg_d;

  always_comb begin
    sh_d = {sh_q[SHORT_LEN-2:0], sh_q[SHORT_LEN-1] ^ sh_q[SHORT_TAP]};
    lg_d = {lg_q[LONG_LEN-2:0],  lg_q[LONG_LEN-1]  ^ lg_q[LONG_TAP]};
    noise_bit = short_sel ? sh_q[0] : lg_q[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1;
      lg_q <= '1;
    end else begin
      sh_q <= sh_d;
      lg_q <= lg_d;
    end
  end
endmodule

// File: rtl/snd_div_pair.sv
module snd_div_pair #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_lo,
  input  logic          en_hi,
  input  logic          joined,
  input  logic [DW-1:0] rl_lo,
  input  logic [DW-1:0] rl_hi,
  output logic          uf_lo,
  output logic          uf_hi
);
  localparam int                 WW    = 2 * DW;
  localparam logic [WW-1:0]      ONE_W = WW'(1);
  localparam logic [DW-1:0]      ONE_B = DW'(1);

  logic [WW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    uf_lo = 1'b0;
    uf_hi = 1'b0;
    if (joined) begin
      if (en_lo) begin
        uf_lo = (cnt_q[DW-1:0] == '0);
        if (cnt_q == '0) begin
          cnt_d = {rl_hi, rl_lo};
          uf_hi = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE_W;
        end
      end
    end else begin
      if (en_lo) begin
        if (cnt_q[DW-1:0] == '0) begin
          cnt_d[DW-1:0] = rl_lo;
          uf_lo         = 1'b1;
        end else begin
          cnt_d[DW-1:0] = cnt_q[DW-1:0] - ONE_B;
        end
      end
      if (en_hi) begin
        if (cnt_q[WW-1:DW] == '0) begin
          cnt_d[WW-1:DW] = rl_hi;
          uf_hi          = 1'b1;
        end else begin
          cnt_d[WW-1:DW] = cnt_q[WW-1:DW] - ONE_B;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/quad_tone_divider.sv
module quad_tone_divider
  import snd_div_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CH_N     = 4,
  parameter int ADDR_W   = 3,
  parameter int PRE_FAST = 28,
  parameter int PRE_SLOW = 114
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CH_N-1:0]   chan_out
);
  localparam int PAIR_N = CH_N / 2;
  localparam int IDX_W  = $clog2(CH_N);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // configuration registers
  logic [DATA_W-1:0] opt_q, opt_d;
  logic [DATA_W-1:0] rl_q [CH_N];
  logic [DATA_W-1:0] rl_d [CH_N];
  logic [CH_N-1:0]   noise_q, noise_d;

  always_comb begin
    opt_d   = opt_q;
    rl_d    = rl_q;
    noise_d = noise_q;
    if (wr_en) begin
      if (wr_addr == ADDR_W'(A_OPTION))
        opt_d = wr_data;
      else if (wr_addr == ADDR_W'(A_NOISE_MASK))
        noise_d = wr_data[CH_N-1:0];
      else if (wr_addr < ADDR_W'(A_RELOAD_BASE + CH_N))
        rl_d[wr_addr[IDX_W-1:0]] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      opt_q   <= '0;
      noise_q <= '0;
      for (int i = 0; i < CH_N; i++) rl_q[i] <= '0;
    end else begin
      opt_q   <= opt_d;
      noise_q <= noise_d;
      rl_q    <= rl_d;
    end
  end

  // shared timing sources
  logic tick, poly_bit;

  snd_div_prescaler #(.DIV_FAST(PRE_FAST), .DIV_SLOW(PRE_SLOW)) u_pre (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .slow_sel (opt_q[OPT_SLOW_TICK]),
    .tick     (tick)
  );

  snd_div_poly u_poly (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .short_sel (opt_q[OPT_POLY_SHORT]),
    .noise_bit (poly_bit)
  );

  // divider pairs, filters and outputs
  logic [CH_N-1:0]   uf;
  logic [CH_N-1:0]   raw_q, raw_d;
  logic [PAIR_N-1:0] hp_q, hp_d;

  for (genvar p = 0; p < PAIR_N; p++) begin : g_pair
    localparam int FB = (p == 0) ? OPT_FAST_CH1 : OPT_FAST_CH3;
    localparam int JB = (p == 0) ? OPT_JOIN12   : OPT_JOIN34;
    localparam int HB = (p == 0) ? OPT_HP_CH1   : OPT_HP_CH3;

    logic en_lo;
    assign en_lo = opt_q[FB] ? 1'b1 : tick;

    snd_div_pair #(.DW(DATA_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .en_lo  (en_lo),
      .en_hi  (tick),
      .joined (opt_q[JB]),
      .rl_lo  (rl_q[2*p]),
      .rl_hi  (rl_q[2*p+1]),
      .uf_lo  (uf[2*p]),
      .uf_hi  (uf[2*p+1])
    );

    assign hp_d[p] = uf[2*p+1] ? raw_q[2*p] : hp_q[p];

    assign chan_out[2*p]   = opt_q[JB] ? 1'b0
                                       : (raw_q[2*p] ^ (opt_q[HB] & hp_q[p]));
    assign chan_out[2*p+1] = raw_q[2*p+1];
  end

  always_comb begin
    raw_d = raw_q;
    for (int i = 0; i < CH_N; i++) begin
      if (uf[i]) raw_d[i] = noise_q[i] ? poly_bit : ~raw_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      raw_q <= '0;
      hp_q  <= '0;
    end else begin
      raw_q <= raw_d;
      hp_q  <= hp_d;
    end
  end
endmodule

// File: rtl/snd_div_checker.sv
module snd_div_checker #(
  parameter int CH_N = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic [CH_N-1:0] uf,
  input logic [CH_N-1:0] raw,
  input logic [1:0]      hp,
  input logic [CH_N-1:0] chan_out
);
  // R1: outputs are quiet in the first cycle after reset release
  a_r1_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> (chan_out == '0))
    else $error("a_r1_reset_quiet");

  // R4: base ticks are never back to back
  a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick)
    else $error("a_r4_tick_spacing");

  // R3 / R7: a divider output only moves on its own underflow
  for (genvar i = 0; i < CH_N; i++) begin : g_raw
    a_r7_raw_on_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      !uf[i] |=> $stable(raw[i]))
      else $error("a_r7_raw_on_underflow ch%0d", i + 1);
  end

  // R9: filter flops sample only when the clocking channel underflows
  a_r9_hp1_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !uf[1] |=> $stable(hp[0]))
    else $error("a_r9_hp1_sample");

  a_r9_hp3_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !uf[3] |=> $stable(hp[1]))
    else $error("a_r9_hp3_sample");
endmodule

bind quad_tone_divider snd_div_checker #(.CH_N(CH_N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .tick     (tick),
  .uf       (uf),
  .raw      (raw_q),
  .hp       (hp_q),
  .chan_out (chan_out)
);

// File: tb/tb_quad_tone_divider.sv
module tb_quad_tone_divider;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [3:0] chan_out;

  int n_checks = 0;
  int n_err    = 0;
  int cyc      = 0;
  bit done     = 0;
  logic smp [0:1021];

  quad_tone_divider dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .chan_out(chan_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  endtask

  task automatic do_reset();
    wr_en = 0; wr_addr = '0; wr_data = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1; wr_addr = 3'(addr); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 0;
  endtask

  // skip the first toggle, then check two full intervals
  task automatic check_period(input int ch, input int exp, input string req);
    logic prev;
    int   last = 0;
    int   seen = 0;
    int   guard = 0;
    @(negedge clk);
    prev = chan_out[ch];
    while (seen < 3 && guard < 4 * exp + 600) begin
      @(negedge clk);
      guard++;
      if (chan_out[ch] !== prev) begin
        prev = chan_out[ch];
        if (seen > 0) chk((cyc - last) == exp, req, cyc - last, exp);
        last = cyc;
        seen++;
      end
    end
    if (seen < 3) chk(1'b0, {req, " no toggle"}, seen, 3);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    do_reset();
    // R1: reset state
    chk(chan_out == 4'b0000, "R1 reset outputs", int'(chan_out), 0);
    repeat (60) @(negedge clk);
    chk(chan_out == 4'b0000, "R1 reset outputs idle", int'(chan_out), 0);

    // R5 / R3: fast channel 1 sweep
    wr(4, 8'h40);
    for (int n = 0; n <= 40; n++) begin
      wr(0, n);
      check_period(0, n + 1, "R5 R3 ch1 fast");
    end
    wr(0, 255);
    check_period(0, 256, "R3 ch1 fast reload 255");

    // R5: fast channel 3 sweep
    do_reset();
    wr(4, 8'h20);
    for (int n = 0; n <= 20; n++) begin
      wr(2, n);
      check_period(2, n + 1, "R5 R3 ch3 fast");
    end

    // R4: base tick rates, R2 addresses
    do_reset();
    wr(0, 0);
    check_period(0, 28, "R4 ch1 base tick");
    wr(1, 3);
    check_period(1, 112, "R4 R2 ch2 reload 3");
    wr(4, 8'h01);
    wr(3, 1);
    check_period(3, 228, "R4 R2 ch4 slow tick");

    // R6: joined 1/2
    do_reset();
    wr(4, 8'h50);
    wr(0, 3);
    wr(1, 1);
    check_period(1, 260, "R6 join12 period");
    begin
      int ones = 0;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (chan_out[0]) ones++;
      end
      chk(ones == 0, "R6 join12 low channel silent", ones, 0);
    end

    // R6: joined 3/4
    do_reset();
    wr(4, 8'h28);
    wr(2, 8'h10);
    check_period(3, 17, "R6 join34 period");
    wr(3, 2);
    wr(2, 0);
    check_period(3, 513, "R6 join34 wrap 0x0200");

    // R9: filter with lockstep underflows stays high
    do_reset();
    wr(4, 8'h06);
    wr(0, 2); wr(1, 2); wr(2, 1); wr(3, 1);
    repeat (300) @(negedge clk);
    begin
      int z1 = 0;
      int z3 = 0;
      for (int k = 0; k < 400; k++) begin
        @(negedge clk);
        if (!chan_out[0]) z1++;
        if (!chan_out[2]) z3++;
      end
      chk(z1 == 0, "R9 ch1 high-pass DC", z1, 0);
      chk(z3 == 0, "R9 ch3 high-pass DC", z3, 0);
    end
    check_period(1, 84, "R3 ch2 clocking channel");

    // R7: noise changes only on base-tick underflows
    do_reset();
    wr(4, 8'h80);
    wr(5, 8'h04);
    wr(2, 0);
    begin
      logic prev;
      int   first = -1;
      int   nchg = 0;
      int   bad = 0;
      @(negedge clk);
      prev = chan_out[2];
      for (int k = 0; k < 3000; k++) begin
        @(negedge clk);
        if (chan_out[2] !== prev) begin
          prev = chan_out[2];
          if (first < 0) first = cyc;
          else if (((cyc - first) % 28) != 0) bad++;
          nchg++;
        end
      end
      chk(bad == 0, "R7 noise aligned to underflow", bad, 0);
      chk(nchg > 5, "R7 noise active", nchg, 6);
    end

    // R8: 9-bit polynomial period 511
    do_reset();
    wr(4, 8'hC0);
    wr(5, 8'h01);
    wr(0, 0);
    repeat (20) @(negedge clk);
    for (int k = 0; k < 1022; k++) begin
      @(negedge clk);
      smp[k] = chan_out[0];
    end
    begin
      int mis = 0;
      int ones = 0;
      for (int k = 0; k < 511; k++) begin
        if (smp[k] !== smp[k + 511]) mis++;
        if (smp[k]) ones++;
      end
      chk(mis == 0, "R8 poly9 period 511", mis, 0);
      chk(ones == 256, "R8 poly9 ones per period", ones, 256);
    end

    // R8: 17-bit polynomial does not repeat at 511
    wr(4, 8'h40);
    repeat (20) @(negedge clk);
    for (int k = 0; k < 1022; k++) begin
      @(negedge clk);
      smp[k] = chan_out[0];
    end
    begin
      int mis = 0;
      for (int k = 0; k < 511; k++) if (smp[k] !== smp[k + 511]) mis++;
      chk(mis > 0, "R8 poly17 not period 511", mis, 1);
    end

    finish_run();
  end
endmodule